// File: doc/BRIEF.md
# Configuration File Header Parser

This block sits in the path of a byte stream that carries an FPGA configuration file. It checks that the stream opens with a fixed 13-byte preamble. It then walks the tagged sections that follow. Each section has a one-byte tag, a big-endian length and a body. Descriptive sections are consumed and dropped. The section tagged `e` is the one that matters: its length field is four bytes wide instead of two. The block captures that length and then forwards exactly that many following bytes as the raw configuration payload.

Input bytes arrive with a valid/ready handshake. In the payload phase the input and output handshakes are tied directly together: a payload byte leaves in the same cycle it is accepted, and the downstream ready stalls the source. Once the payload has been counted out, or after any format error, the block stops accepting bytes. A synchronous restart returns it to the start of the preamble.

Top module: `cfg_hdr_parser`

## Requirements
- R1: After reset the block accepts input (`in_ready`=1) and shows `hdr_ok`=0, `err`=0, `done`=0, `data_len`=0 and `pay_valid`=0.
- R2: The first 13 accepted bytes must equal 00 09 0F F0 0F F0 0F F0 0F F0 00 00 01 in that order. A mismatch at any position sets `err` in the cycle after that byte is accepted.
- R3: A section tag byte outside the range 0x61..0x65 (ASCII `a`..`e`) sets `err` in the cycle after it is accepted.
- R4: A section tagged 0x61..0x64 carries a 2-byte length, high byte first, followed by that many body bytes. All of these bytes are accepted and none is presented on the payload output.
- R5: A section tagged 0x65 carries a 4-byte length, high byte first. In the cycle after its last length byte is accepted, `data_len` holds that length and `hdr_ok` is 1. Both then stay unchanged until restart.
- R6: In the payload phase, `pay_valid` follows `in_valid`, `pay_data` equals `in_data`, and `in_ready` equals `pay_ready` in the same cycle. Bytes are passed through unchanged, in order.
- R7: Exactly `data_len` payload bytes are forwarded, and `pay_last` is 1 on the final one. In the following cycle `done` is 1 and `in_ready` is 0.
- R8: `restart` clears `err`, `done`, `hdr_ok` and `data_len` at the next clock edge and resumes preamble comparison from the first byte. It takes priority over a byte offered in the same cycle.
- R9: A zero length in a 0x61..0x64 section goes straight to the next tag. A zero length in the 0x65 section sets `hdr_ok` and `done` together with no payload.
- R10: Once set, `err` stays 1, `in_ready` stays 0 and no payload is presented until restart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| restart | input | 1 | Synchronous return to preamble compare |
| in_data | input | 8 | Incoming file byte |
| in_valid | input | 1 | Incoming byte is present |
| in_ready | output | 1 | Block accepts the byte this cycle |
| pay_data | output | 8 | Payload byte |
| pay_valid | output | 1 | Payload byte is present |
| pay_ready | input | 1 | Downstream accepts the payload byte |
| pay_last | output | 1 | Final payload byte |
| hdr_ok | output | 1 | Header parsed, payload length captured |
| err | output | 1 | Format error, parsing halted |
| done | output | 1 | Whole payload forwarded |
| data_len | output | 32 | Captured payload length in bytes |

## Verification
Every status result (`err`, `hdr_ok`, `data_len`, `done`) is due exactly one edge after the byte that causes it is accepted. `in_ready`, `pay_valid`, `pay_data` and `pay_last` are combinational in the same cycle as the offered byte. The bench drives each byte just after a falling edge and lets the logic settle. It reads the same-cycle handshake and payload outputs before the rising edge that accepts the byte. It reads the status outputs just after the next falling edge, which is one register stage later. Backpressure and sticky-error checks hold inputs across several edges and sample at the same falling-edge points.

// File: rtl/cfg_hdr_parser.sv
module cfg_hdr_parser (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        restart,
  input  logic [7:0]  in_data,
  input  logic        in_valid,
  output logic        in_ready,
  output logic [7:0]  pay_data,
  output logic        pay_valid,
  input  logic        pay_ready,
  output logic        pay_last,
  output logic        hdr_ok,
  output logic        err,
  output logic        done,
  output logic [31:0] data_len
);

  localparam logic [3:0] PRE_LAST = 4'd12;
  localparam logic [7:0] TAG_LO   = 8'h61;
  localparam logic [7:0] TAG_HI   = 8'h65;

  typedef enum logic [2:0] {S_PRE, S_TAG, S_LEN, S_SKIP, S_PAY, S_DONE, S_ERR} st_t;

  st_t         st;
  logic [3:0]  pidx;
  logic [1:0]  lcnt;
  logic        is_e;
  logic [31:0] shreg;
  logic [31:0] cnt;
  logic [31:0] nxt_len;
  logic        acc;

  function automatic logic [7:0] pre_byte(input logic [3:0] i);
    case (i)
      4'd0, 4'd10, 4'd11: pre_byte = 8'h00;
      4'd1:               pre_byte = 8'h09;
      4'd12:              pre_byte = 8'h01;
      default:            pre_byte = i[0] ? 8'hF0 : 8'h0F;
    endcase
  endfunction

  assign in_ready  = (st == S_PRE) || (st == S_TAG) || (st == S_LEN) || (st == S_SKIP) ||
                     ((st == S_PAY) && pay_ready);
  assign acc       = in_valid && in_ready;
  assign nxt_len   = {shreg[23:0], in_data};
  assign pay_valid = (st == S_PAY) && in_valid;
  assign pay_data  = in_data;
  assign pay_last  = (st == S_PAY) && (cnt == 32'd1);
  assign err       = (st == S_ERR);
  assign done      = (st == S_DONE);

  always_ff @(posedge clk) begin
    if (!rst_n || restart) begin
      st       <= S_PRE;
      pidx     <= '0;
      lcnt     <= '0;
      is_e     <= 1'b0;
      shreg    <= '0;
      cnt      <= '0;
      hdr_ok   <= 1'b0;
      data_len <= '0;
    end else if (acc) begin
      case (st)
        S_PRE: begin
          if (in_data != pre_byte(pidx)) st <= S_ERR;
          else if (pidx == PRE_LAST)     st <= S_TAG;
          else                           pidx <= pidx + 4'd1;
        end
        S_TAG: begin
          if (in_data >= TAG_LO && in_data <= TAG_HI) begin
            is_e  <= (in_data == TAG_HI);
            lcnt  <= (in_data == TAG_HI) ? 2'd3 : 2'd1;
            shreg <= '0;
            st    <= S_LEN;
          end else begin
            st <= S_ERR;
          end
        end
        S_LEN: begin
          shreg <= nxt_len;
          lcnt  <= lcnt - 2'd1;
          if (lcnt == 2'd0) begin
            cnt <= nxt_len;
            if (is_e) begin
              data_len <= nxt_len;
              hdr_ok   <= 1'b1;
              st       <= (nxt_len == 32'd0) ? S_DONE : S_PAY;
            end else begin
              st <= (nxt_len == 32'd0) ? S_TAG : S_SKIP;
            end
          end
        end
        S_SKIP: begin
          cnt <= cnt - 32'd1;
          if (cnt == 32'd1) st <= S_TAG;
        end
        S_PAY: begin
          cnt <= cnt - 32'd1;
          if (cnt == 32'd1) st <= S_DONE;
        end
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/cfg_hdr_parser_chk.sv
module cfg_hdr_parser_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        restart,
  input logic        in_valid,
  input logic        in_ready,
  input logic        pay_valid,
  input logic        pay_ready,
  input logic        pay_last,
  input logic        hdr_ok,
  input logic        err,
  input logic        done,
  input logic [31:0] data_len
);

  a_r10_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    err && !restart |=> err);

  a_r10_err_halts: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> !in_ready && !pay_valid);

  a_r7_done_halts: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !in_ready && !pay_valid);

  a_r7_last_then_done: assert property (@(posedge clk) disable iff (!rst_n)
    pay_valid && pay_ready && pay_last && !restart |=> done);

  a_r5_len_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    hdr_ok && !restart |=> hdr_ok && $stable(data_len));

  a_r8_restart_clears: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> !err && !done && !hdr_ok && data_len == 32'd0);

  a_r6_ready_follows: assert property (@(posedge clk) disable iff (!rst_n)
    pay_valid |-> in_valid && (in_ready == pay_ready));

  a_r2_err_excl_ok: assert property (@(posedge clk) disable iff (!rst_n)
    !(err && hdr_ok));

endmodule

bind cfg_hdr_parser cfg_hdr_parser_chk u_chk (.*);

// File: tb/tb_cfg_hdr_parser.sv
module tb_cfg_hdr_parser;
  logic clk = 1'b0, rst_n = 1'b0, restart = 1'b0;
  logic [7:0] in_data = '0;
  logic in_valid = 1'b0, pay_ready = 1'b1;
  logic in_ready, pay_valid, pay_last, hdr_ok, err, done;
  logic [7:0] pay_data;
  logic [31:0] data_len;
  int checks = 0, errors = 0;
  int stray = 0, pbad = 0, lbad = 0;

  always #10 clk = ~clk;

  cfg_hdr_parser dut (.*);

  // rows: tag, body length, payload length, bad tag expected
  localparam logic [40:0] ROWS [6] = '{
    {8'h61, 16'd3,   16'd5, 1'b0},
    {8'h62, 16'd0,   16'd1, 1'b0},
    {8'h63, 16'd300, 16'd2, 1'b0},
    {8'h64, 16'd1,   16'd0, 1'b0},
    {8'h66, 16'd2,   16'd4, 1'b1},
    {8'h60, 16'd1,   16'd1, 1'b1}
  };

  function automatic logic [7:0] pre(input int i);
    logic [7:0] t [13] = '{8'h00,8'h09,8'h0F,8'hF0,8'h0F,8'hF0,8'h0F,8'hF0,8'h0F,8'hF0,8'h00,8'h00,8'h01};
    return t[i];
  endfunction

  function automatic logic [7:0] pb(input int i);
    return 8'(i * 7 + 3);
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic send(input logic [7:0] b, input bit exp_pay, input bit exp_last);
    in_data = b; in_valid = 1'b1; #1;
    while (!in_ready) begin @(negedge clk); #1; end
    if (exp_pay) begin
      if (!pay_valid || pay_data !== b) pbad++;
      if (pay_last !== exp_last) lbad++;
    end else if (pay_valid) stray++;
    @(posedge clk); @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic do_restart();
    restart = 1'b1; @(posedge clk); @(negedge clk); restart = 1'b0;
    stray = 0; pbad = 0; lbad = 0;
  endtask

  task automatic send_pre();
    for (int i = 0; i < 13; i++) send(pre(i), 1'b0, 1'b0);
  endtask

  task automatic send_e(input logic [31:0] n);
    send(8'h65, 0, 0);
    for (int k = 3; k >= 0; k--) send(n[8*k +: 8], 0, 0);
  endtask

  task automatic send_payload(input int n);
    for (int i = 0; i < n; i++) send(pb(i), 1'b1, i == n - 1);
  endtask

  task automatic run_row(input logic [40:0] r);
    logic [7:0] tag = r[40:33];
    logic [15:0] sl = r[32:17];
    logic [15:0] el = r[16:1];
    do_restart();
    send_pre();
    send(tag, 0, 0); #1;
    if (r[0]) begin
      check("R3 bad tag err", err, 1);
      check("R3 bad tag in_ready", in_ready, 0);
      return;
    end
    send(sl[15:8], 0, 0); send(sl[7:0], 0, 0);
    for (int i = 0; i < sl; i++) send(8'hA5, 0, 0);
    send_e({16'd0, el}); #1;
    check("R5 hdr_ok", hdr_ok, 1);
    check("R5 data_len", data_len, {16'd0, el});
    if (el == 0) check("R9 zero e done", done, 1);
    send_payload(el); #1;
    check("R4 no payload during skip", stray, 0);
    check("R6 payload bytes", pbad, 0);
    check("R7 last flag", lbad, 0);
    check("R7 done", done, 1);
    check("R7 in_ready low", in_ready, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1; #1;
    check("R1 in_ready", in_ready, 1);
    check("R1 hdr_ok", hdr_ok, 0);
    check("R1 err", err, 0);
    check("R1 done", done, 0);
    check("R1 data_len", data_len, 0);
    check("R1 pay_valid", pay_valid, 0);

    for (int i = 0; i < 6; i++) run_row(ROWS[i]);

    // R2: mismatch at first and last preamble position
    do_restart();
    send(8'h01, 0, 0); #1;
    check("R2 mismatch pos0", err, 1);
    do_restart();
    for (int i = 0; i < 12; i++) send(pre(i), 0, 0);
    #1 check("R2 no err before mismatch", err, 0);
    send(8'h00, 0, 0); #1;
    check("R2 mismatch pos12", err, 1);
    // R10: error sticky while bytes keep coming
    in_valid = 1'b1; in_data = 8'h61;
    repeat (3) @(negedge clk);
    #1;
    check("R10 err sticky", err, 1);
    check("R10 in_ready low", in_ready, 0);
    check("R10 no payload", pay_valid, 0);
    in_valid = 1'b0;
    do_restart(); #1;
    check("R8 err cleared", err, 0);
    check("R8 in_ready", in_ready, 1);

    // R5/R6: 'e' first, 4-byte length 0x103, with backpressure
    send_pre();
    send_e(32'h0000_0103); #1;
    check("R5 four-byte length", data_len, 32'h103);
    pay_ready = 1'b0; in_valid = 1'b1; in_data = 8'h3C; #1;
    check("R6 stall in_ready", in_ready, 0);
    check("R6 stall pay_valid", pay_valid, 1);
    check("R6 pay_data pass", pay_data, 8'h3C);
    @(posedge clk); @(negedge clk);
    pay_ready = 1'b1; in_valid = 1'b0;
    send_payload(259); #1;
    check("R6 long payload", pbad, 0);
    check("R7 long last", lbad, 0);
    check("R7 long done", done, 1);

    // R8: restart mid-payload, restart wins over offered byte
    do_restart();
    send_pre(); send_e(32'd10);
    send_payload(3);
    in_valid = 1'b1; in_data = 8'h77; restart = 1'b1;
    @(posedge clk); @(negedge clk);
    restart = 1'b0; in_valid = 1'b0; #1;
    check("R8 hdr_ok cleared", hdr_ok, 0);
    check("R8 data_len cleared", data_len, 0);
    check("R8 in_ready", in_ready, 1);
    stray = 0; pbad = 0; lbad = 0;
    send_pre(); send_e(32'd2); send_payload(2); #1;
    check("R8 reparse done", done, 1);
    check("R8 reparse payload", pbad, 0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule